// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit resolves a relative branch. It takes three things: a 4-bit condition selector, the four condition flags (negative, zero, overflow, carry) and the program counter of the instruction that follows the branch. From these it decides whether the branch is taken. When it is taken, the next program counter is the current one plus a sign-extended displacement. When it is not taken, the next program counter is the current one unchanged.

The displacement comes from one 16-bit input. In the short form only its low byte is used, sign-extended. In the long form all 16 bits are used. The supported conditions are:

- branch-always and branch-never;
- the eight single-flag tests;
- four signed magnitude tests, which judge the sign corrected for overflow;
- four unsigned magnitude tests, which use carry and zero and never the negative flag.

A pipeline places one request on the inputs and pulses the valid strobe. Both results appear registered one clock edge later and hold until the next strobe. Fetching instructions, decoding the opcode into the selector and producing the flags are done elsewhere.

Top module: `cbt_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, taken_out is 0 and next_pc_out is 0x0000.
- R2: Both outputs load on the rising clock edge at which valid_in is 1, so they are visible one cycle after the strobe. On edges with valid_in at 0 they keep their values, whatever the other inputs do.
- R3: Selector 0 (always) is always taken and selector 1 (never) is never taken, for any flags. The two codes differ only in bit 0. For every selector, bit 0 inverts the test named by bits 3:1.
- R4: The single-flag selectors are taken as follows: 6 when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0, 11 when N=1.
- R5: Unsigned higher (selector 2) is taken when C and Z are both 0. Unsigned lower-or-same (selector 3) is taken when C or Z is 1.
- R6: Selector 4 means carry-clear and also unsigned higher-or-same. Selector 5 means carry-set and also unsigned lower. Both follow C only. With N=0, Z=0, V=1, C=0 (the flags left by 0x80 minus 0x32), selector 4 is taken.
- R7: Signed greater-or-equal (selector 12) is taken when N equals V. Signed less (selector 13) is taken when N differs from V. This holds when V is 1 as well.
- R8: Signed greater (selector 14) is taken when Z is 0 and N equals V. Signed less-or-equal (selector 15) is taken when Z is 1 or N differs from V.
- R9: With long_sel at 0, the displacement is offset_in[7:0] sign-extended to 16 bits. offset_in[15:8] has no effect.
- R10: With long_sel at 1, the displacement is offset_in[15:0] taken as a two's-complement value.
- R11: When the branch is not taken, next_pc_out equals pc_in, for either offset form.
- R12: A taken target is pc_in plus the displacement modulo 2^16, wrapping in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe; loads the result registers |
| cond_sel | input | 4 | Branch condition selector (codes in R3 to R8) |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address following the branch instruction |
| long_sel | input | 1 | 1 selects the 16-bit displacement, 0 the 8-bit one |
| offset_in | input | 16 | Displacement field |
| taken_out | output | 1 | Registered branch decision |
| next_pc_out | output | 16 | Registered next program counter |

## Verification
The taken flag and the next PC both come from one register stage. Each is therefore due exactly one rising edge after the cycle in which valid_in is high. The bench drives a request on a falling edge and lets one rising edge pass. It then reads both outputs on the following falling edge, so no read races the register update. The hold checks drop the strobe, change every other input, let further edges pass, and read the outputs again at the same falling-edge point.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Bit 0 of every code inverts the test named by bits 3:1.
    typedef enum logic [3:0] {
        SEL_ALWAYS = 4'd0,
        SEL_NEVER  = 4'd1,
        SEL_HI     = 4'd2,
        SEL_LS     = 4'd3,
        SEL_HS     = 4'd4,
        SEL_LO     = 4'd5,
        SEL_NE     = 4'd6,
        SEL_EQ     = 4'd7,
        SEL_VC     = 4'd8,
        SEL_VS     = 4'd9,
        SEL_PL     = 4'd10,
        SEL_MI     = 4'd11,
        SEL_GE     = 4'd12,
        SEL_LT     = 4'd13,
        SEL_GT     = 4'd14,
        SEL_LE     = 4'd15
    } cond_sel_e;

    // Test pairs addressed by selector bits 3:1.
    typedef enum logic [2:0] {
        PAIR_TRUE  = 3'd0,
        PAIR_UHI   = 3'd1,
        PAIR_CCLR  = 3'd2,
        PAIR_ZCLR  = 3'd3,
        PAIR_VCLR  = 3'd4,
        PAIR_NCLR  = 3'd5,
        PAIR_SGE   = 3'd6,
        PAIR_SGT   = 3'd7
    } cond_pair_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/cbt_cond_eval.sv
module cbt_cond_eval
    import cbt_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     flags,
    output logic       take
);

    cond_pair_e pair;
    logic       base;
    logic       sgn_lt;

    assign pair   = cond_pair_e'(sel[3:1]);
    assign sgn_lt = flags.n ^ flags.v;

    always_comb begin
        unique case (pair)
            PAIR_TRUE: base = 1'b1;
            PAIR_UHI:  base = ~(flags.c | flags.z);
            PAIR_CCLR: base = ~flags.c;
            PAIR_ZCLR: base = ~flags.z;
            PAIR_VCLR: base = ~flags.v;
            PAIR_NCLR: base = ~flags.n;
            PAIR_SGE:  base = ~sgn_lt;
            PAIR_SGT:  base = ~(flags.z | sgn_lt);
            default:   base = 1'b0;
        endcase
    end

    assign take = base ^ sel[0];

endmodule

// File: rtl/cbt_target_add.sv
module cbt_target_add #(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              use_long,
    input  logic [LONG_W-1:0] disp,
    output logic [PC_W-1:0]   target
);

    localparam int SHORT_PAD = PC_W - SHORT_W;
    localparam int LONG_PAD  = PC_W - LONG_W;

    logic [PC_W-1:0] ext_short;
    logic [PC_W-1:0] ext_long;

    assign ext_short = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

    generate
        if (LONG_PAD > 0) begin : g_long_pad
            assign ext_long = {{LONG_PAD{disp[LONG_W-1]}}, disp};
        end else begin : g_long_full
            assign ext_long = disp[PC_W-1:0];
        end
    endgenerate

    // Sum truncated to PC_W bits: modulo wrap.
    assign target = pc + (use_long ? ext_long : ext_short);

endmodule

// File: rtl/cbt_unit.sv
module cbt_unit
    import cbt_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [3:0]        cond_sel,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              long_sel,
    input  logic [LONG_W-1:0] offset_in,
    output logic              taken_out,
    output logic [PC_W-1:0]   next_pc_out
);

    flags_t          flags;
    logic            take;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] pc_nxt;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    cbt_cond_eval u_cond (
        .sel   (cond_sel),
        .flags (flags),
        .take  (take)
    );

    cbt_target_add #(
        .PC_W    (PC_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) u_add (
        .pc       (pc_in),
        .use_long (long_sel),
        .disp     (offset_in),
        .target   (target)
    );

    always_comb begin
        pc_nxt = take ? target : pc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_out   <= 1'b0;
            next_pc_out <= '0;
        end else if (valid_in) begin
            taken_out   <= take;
            next_pc_out <= pc_nxt;
        end
    end

endmodule

// File: rtl/cbt_unit_chk.sv
module cbt_unit_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_in,
    input logic [3:0]      cond_sel,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_v,
    input logic            flag_c,
    input logic [PC_W-1:0] pc_in,
    input logic            taken_out,
    input logic [PC_W-1:0] next_pc_out
);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(taken_out) && $stable(next_pc_out)));

    // R3
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cond_sel == 4'd0) |=> taken_out);

    // R3
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cond_sel == 4'd1) |=> !taken_out);

    // R4
    eq_follows_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cond_sel == 4'd7) |=> (taken_out == $past(flag_z)));

    // R6
    hs_follows_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cond_sel == 4'd4) |=> (taken_out == !$past(flag_c)));

    // R7
    ge_sign_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cond_sel == 4'd12) |=> (taken_out == ($past(flag_n) == $past(flag_v))));

    // R11
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in ##1 !taken_out) |-> (next_pc_out == $past(pc_in)));

endmodule

bind cbt_unit cbt_unit_chk #(.PC_W(PC_W)) u_cbt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_in    (valid_in),
    .cond_sel    (cond_sel),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_v      (flag_v),
    .flag_c      (flag_c),
    .pc_in       (pc_in),
    .taken_out   (taken_out),
    .next_pc_out (next_pc_out)
);

// File: tb/test_cbt_unit.sv
module test_cbt_unit;

    // Vector: {sel[4], nzvc[4], long[1], pc[16], off[16], exp_taken[1], exp_pc[16]}
    localparam int NV = 32;
    localparam logic [57:0] VEC [NV] = '{
        {4'd0,  4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R3
        {4'd1,  4'b1111, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R3
        {4'd7,  4'b0100, 1'b0, 16'h1000, 16'h00F0, 1'b1, 16'h0FF0}, // R4
        {4'd6,  4'b0100, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R4
        {4'd10, 4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R4
        {4'd11, 4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R4
        {4'd9,  4'b0010, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R4
        {4'd8,  4'b0010, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R4
        {4'd5,  4'b0001, 1'b0, 16'h1000, 16'h007F, 1'b1, 16'h107F}, // R6
        {4'd4,  4'b0001, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R6
        {4'd4,  4'b0010, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R6
        {4'd2,  4'b0010, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R5
        {4'd3,  4'b0100, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R5
        {4'd2,  4'b0100, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R5
        {4'd3,  4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R5
        {4'd12, 4'b1010, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R7
        {4'd13, 4'b1010, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R7
        {4'd13, 4'b1000, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R7
        {4'd12, 4'b1000, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R7
        {4'd14, 4'b0000, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R8
        {4'd14, 4'b0100, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R8
        {4'd15, 4'b0100, 1'b0, 16'h1000, 16'h0010, 1'b1, 16'h1010}, // R8
        {4'd15, 4'b1010, 1'b0, 16'h1000, 16'h0010, 1'b0, 16'h1000}, // R8
        {4'd0,  4'b0000, 1'b1, 16'h1000, 16'h8000, 1'b1, 16'h9000}, // R10
        {4'd0,  4'b0000, 1'b1, 16'h1000, 16'hFF00, 1'b1, 16'h0F00}, // R10
        {4'd0,  4'b0000, 1'b1, 16'h1000, 16'h0180, 1'b1, 16'h1180}, // R10
        {4'd0,  4'b0000, 1'b0, 16'h1000, 16'hAB10, 1'b1, 16'h1010}, // R9
        {4'd0,  4'b0000, 1'b0, 16'h1000, 16'h0080, 1'b1, 16'h0F80}, // R9
        {4'd0,  4'b0000, 1'b0, 16'hFFF0, 16'h0020, 1'b1, 16'h0010}, // R12
        {4'd0,  4'b0000, 1'b0, 16'h0008, 16'h00F0, 1'b1, 16'hFFF8}, // R12
        {4'd0,  4'b0000, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 16'h0000}, // R12
        {4'd1,  4'b0000, 1'b1, 16'h2345, 16'h1111, 1'b0, 16'h2345}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [15:0] pc_in = '0;
    logic        long_sel = 1'b0;
    logic [15:0] offset_in = '0;
    logic        taken_out;
    logic [15:0] next_pc_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cbt_unit i_cbt_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_in    (valid_in),
        .cond_sel    (cond_sel),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c),
        .pc_in       (pc_in),
        .long_sel    (long_sel),
        .offset_in   (offset_in),
        .taken_out   (taken_out),
        .next_pc_out (next_pc_out)
    );

    function automatic string req_of(int idx);
        if (idx <= 1)  return "R3";
        if (idx <= 7)  return "R4";
        if (idx <= 10) return "R6";
        if (idx <= 14) return "R5";
        if (idx <= 18) return "R7";
        if (idx <= 22) return "R8";
        if (idx <= 25) return "R10";
        if (idx <= 27) return "R9";
        if (idx <= 30) return "R12";
        return "R11";
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [57:0] v, logic strobe);
        cond_sel  = v[57:54];
        flag_n    = v[53];
        flag_z    = v[52];
        flag_v    = v[51];
        flag_c    = v[50];
        long_sel  = v[49];
        pc_in     = v[48:33];
        offset_in = v[32:17];
        valid_in  = strobe;
    endtask

    // Drive at a falling edge, one rising edge loads, read at next falling edge.
    task automatic apply(logic [57:0] v);
        @(negedge clk);
        drive(v, 1'b1);
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "taken in reset", {15'd0, taken_out}, 16'h0000);
        check("R1", "pc in reset", next_pc_out, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(req_of(i), $sformatf("taken vec %0d", i), {15'd0, taken_out}, {15'd0, VEC[i][16]});
            check(req_of(i), $sformatf("pc vec %0d", i), next_pc_out, VEC[i][15:0]);
        end

        // R2: hold with strobe low while inputs change
        apply({4'd0, 4'b0000, 1'b0, 16'h4000, 16'h0004, 1'b1, 16'h4004});
        check("R2", "load taken", {15'd0, taken_out}, 16'h0001);
        check("R2", "load pc", next_pc_out, 16'h4004);
        @(negedge clk);
        drive({4'd1, 4'b1111, 1'b1, 16'h7777, 16'h1234, 1'b0, 16'h0000}, 1'b0);
        repeat (3) @(negedge clk);
        check("R2", "hold taken", {15'd0, taken_out}, 16'h0001);
        check("R2", "hold pc", next_pc_out, 16'h4004);

        // R2: single-cycle latency, strobe after idle
        @(negedge clk);
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check("R2", "strobe after hold taken", {15'd0, taken_out}, 16'h0000);
        check("R2", "strobe after hold pc", next_pc_out, 16'h7777);

        // R1: reset mid-run clears outputs
        apply({4'd0, 4'b0000, 1'b0, 16'h0100, 16'h0001, 1'b1, 16'h0101});
        rst_n = 1'b0;
        #1;
        check("R1", "async reset taken", {15'd0, taken_out}, 16'h0000);
        check("R1", "async reset pc", next_pc_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule